// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This block collects hardware events from a display controller into sticky status bits and turns them into a single interrupt request line. Each event arrives as a one-cycle strobe: an input FIFO overrun or underrun, an output FIFO underrun, a bus error, a frame start or frame end, or a switch to a new set of frame descriptors. Two more events are made inside the block. One counts toggles of the bias output and fires after a programmed number of toggles. The other fires once, when the frame that was running at the moment the controller was disabled finishes.

Software reaches the block through a small register port. Address 0 returns the status bits, and writing a 1 to a status bit clears it. Address 1 holds one mask bit per status bit. A mask bit only keeps its status bit away from the interrupt line. It never changes the status bit itself, and it never stops hardware from setting that bit or software from clearing it. The interrupt output is registered.

Top module: `disp_irq_status`

## Requirements
- R1: Each event sets its own status bit at the next clock edge. Bit positions: 0 input FIFO overrun, 1 input FIFO underrun, 2 output FIFO underrun, 3 bus error, 4 frame start, 5 frame end, 6 last frame done after disable, 7 descriptor branch, 8 bias toggle count reached.
- R2: A status bit stays set until a write to address 0 has a 1 in that bit position. Writing 0 to a bit leaves it unchanged.
- R3: When an event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R4: The mask register sits at address 1, is 9 bits wide, reads back what was written, and resets to all ones (everything masked).
- R5: `irq` is registered. It is high in the cycle after any status bit is set while its mask bit is 0, and low in the cycle after no unmasked status bit remains.
- R6: A mask bit set to 1 keeps its status bit off `irq`. Writing the mask never changes the status bits, and masked bits still get set by events and cleared by writes.
- R7: With `cfg_bias_limit` = N > 0, every N-th `bias_toggle` strobe raises status bit 8 and the toggle count restarts from zero. With N = 0, bit 8 is never raised.
- R8: After `ctrl_enable` has been seen low following a high, the first `ev_frame_end` strobe that arrives while it is still low raises status bit 6 once. Later frame ends do not raise it again until `ctrl_enable` goes high and then low again.
- R9: `reg_rdata` is registered. It shows the register selected by `reg_addr` at the previous clock edge, as that register stood just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in_ovr | input | 1 | Input FIFO overrun strobe |
| ev_in_udr | input | 1 | Input FIFO underrun strobe |
| ev_out_udr | input | 1 | Output FIFO underrun strobe |
| ev_bus_err | input | 1 | Bus error strobe |
| ev_frame_start | input | 1 | Frame start strobe |
| ev_frame_end | input | 1 | Frame end strobe |
| ev_branch | input | 1 | Descriptor branch strobe |
| bias_toggle | input | 1 | One pulse per toggle of the bias output |
| ctrl_enable | input | 1 | Level showing that the display controller is enabled |
| cfg_bias_limit | input | CNT_W | Number of toggles per bias event; 0 turns the event off |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status (write 1 to clear), 1 = mask |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Each strobe is applied on its own, with everything masked, so that the one-hot read-back exposes any swapped or stuck bit position. Write patterns that mix zeros and ones show whether write-1-to-clear touches only the selected bits, and an event that lands in the same cycle as its own clear shows which of the two wins. Masking and unmasking a bit that is already set, and setting bits while they are masked, separate gating of the request from any change to the status bit. Toggle runs of exactly N, N-1 and zero limit, together with frame ends before disable, after disable and repeated after disable, separate correct counting and one-shot behaviour from off-by-one and re-fire faults.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int N_EV = 9;

  localparam int EV_IN_OVR    = 0;
  localparam int EV_IN_UDR    = 1;
  localparam int EV_OUT_UDR   = 2;
  localparam int EV_BUS_ERR   = 3;
  localparam int EV_FRM_START = 4;
  localparam int EV_FRM_END   = 5;
  localparam int EV_LAST_DONE = 6;
  localparam int EV_BRANCH    = 7;
  localparam int EV_BIAS      = 8;

  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_MASK   = 1'b1;

  typedef logic [N_EV-1:0] ev_vec_t;
endpackage

// File: rtl/disp_status_array.sv
module disp_status_array
  import disp_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  ev_vec_t set_i,
  input  ev_vec_t clr_i,
  output ev_vec_t status_o
);
  ev_vec_t st_q;

  // one sticky cell per event; a set beats a clear in the same cycle
  for (genvar i = 0; i < N_EV; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) st_q[i] <= 1'b0;
      else     st_q[i] <= set_i[i] | (st_q[i] & ~clr_i[i]);
    end
  end

  assign status_o = st_q;
endmodule

// File: rtl/disp_bias_counter.sv
module disp_bias_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             toggle_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  localparam int CW1 = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CW1-1:0]   cnt_inc;
  logic             active;
  logic             reach;

  assign active  = (limit_i != '0);
  assign cnt_inc = {1'b0, cnt_q} + CW1'(1);
  // >= keeps a lowered limit from letting the count run past it
  assign reach   = (cnt_inc >= {1'b0, limit_i});
  assign hit_o   = toggle_i & active & reach;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!active) begin
      cnt_q <= '0;
    end else if (toggle_i) begin
      if (reach) cnt_q <= '0;
      else       cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/disp_lastframe_track.sv
module disp_lastframe_track (
  input  logic clk,
  input  logic rst,
  input  logic enable_i,
  input  logic frame_end_i,
  output logic hit_o
);
  logic en_q;
  logic armed_q;

  assign hit_o = armed_q & frame_end_i & ~enable_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      en_q <= enable_i;
      if (enable_i)             armed_q <= 1'b0;
      else if (en_q)            armed_q <= 1'b1;
      else if (hit_o)           armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/disp_reg_port.sv
module disp_reg_port
  import disp_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wr_i,
  input  logic    addr_i,
  input  ev_vec_t wdata_i,
  input  ev_vec_t status_i,
  output ev_vec_t mask_o,
  output ev_vec_t clr_o,
  output ev_vec_t rdata_o
);
  ev_vec_t mask_q;
  ev_vec_t rdata_q;

  assign clr_o = (wr_i && addr_i == ADDR_STATUS) ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      rdata_q <= '0;
    end else begin
      if (wr_i && addr_i == ADDR_MASK) mask_q <= wdata_i;
      rdata_q <= (addr_i == ADDR_MASK) ? mask_q : status_i;
    end
  end

  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
  import disp_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_in_ovr,
  input  logic             ev_in_udr,
  input  logic             ev_out_udr,
  input  logic             ev_bus_err,
  input  logic             ev_frame_start,
  input  logic             ev_frame_end,
  input  logic             ev_branch,
  input  logic             bias_toggle,
  input  logic             ctrl_enable,
  input  logic [CNT_W-1:0] cfg_bias_limit,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [N_EV-1:0]  reg_wdata,
  output logic [N_EV-1:0]  reg_rdata,
  output logic             irq
);
  ev_vec_t ev_vec;
  ev_vec_t status_q;
  ev_vec_t mask_q;
  ev_vec_t clr_v;
  logic    bias_hit;
  logic    last_hit;
  logic    irq_q;

  disp_bias_counter #(.CNT_W(CNT_W)) u_bias (
    .clk(clk), .rst(rst), .toggle_i(bias_toggle),
    .limit_i(cfg_bias_limit), .hit_o(bias_hit)
  );

  disp_lastframe_track u_last (
    .clk(clk), .rst(rst), .enable_i(ctrl_enable),
    .frame_end_i(ev_frame_end), .hit_o(last_hit)
  );

  always_comb begin
    ev_vec               = '0;
    ev_vec[EV_IN_OVR]    = ev_in_ovr;
    ev_vec[EV_IN_UDR]    = ev_in_udr;
    ev_vec[EV_OUT_UDR]   = ev_out_udr;
    ev_vec[EV_BUS_ERR]   = ev_bus_err;
    ev_vec[EV_FRM_START] = ev_frame_start;
    ev_vec[EV_FRM_END]   = ev_frame_end;
    ev_vec[EV_LAST_DONE] = last_hit;
    ev_vec[EV_BRANCH]    = ev_branch;
    ev_vec[EV_BIAS]      = bias_hit;
  end

  disp_reg_port u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .status_i(status_q), .mask_o(mask_q),
    .clr_o(clr_v), .rdata_o(reg_rdata)
  );

  disp_status_array u_stat (
    .clk(clk), .rst(rst), .set_i(ev_vec), .clr_i(clr_v), .status_o(status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status_q & ~mask_q);
  end

  assign irq = irq_q;
endmodule

// File: rtl/disp_irq_status_chk.sv
module disp_irq_status_chk
  import disp_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input ev_vec_t          ev_vec,
  input ev_vec_t          status,
  input ev_vec_t          mask,
  input logic             irq,
  input logic             reg_wr,
  input logic             reg_addr,
  input ev_vec_t          reg_wdata,
  input logic             ctrl_enable,
  input logic [CNT_W-1:0] bias_limit,
  input logic             bias_hit
);
  ev_vec_t clr_seen;
  ev_vec_t keep_v;
  assign clr_seen = (reg_wr && reg_addr == ADDR_STATUS) ? reg_wdata : '0;
  assign keep_v   = status & ~clr_seen;

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
    (|ev_vec) |=> ((status & $past(ev_vec)) == $past(ev_vec))); // R1

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (|keep_v) |=> ((status & $past(keep_v)) == $past(keep_v))); // R2

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(status & ~mask)) |=> irq); // R5

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    !(|(status & ~mask)) |=> !irq); // R5

  AST_MASK_WR_KEEPS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_MASK && ev_vec == '0) |=> $stable(status)); // R6

  AST_BIAS_OFF: assert property (@(posedge clk) disable iff (rst)
    (bias_limit == '0) |-> !bias_hit); // R7

  AST_LAST_WHILE_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(status[EV_LAST_DONE]) |-> !$past(ctrl_enable)); // R8
endmodule

bind disp_irq_status disp_irq_status_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .ev_vec(ev_vec), .status(status_q), .mask(mask_q),
  .irq(irq), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .ctrl_enable(ctrl_enable), .bias_limit(cfg_bias_limit), .bias_hit(bias_hit)
);

// File: tb/test_disp_irq_status.sv
`timescale 1ns/1ps
module test_disp_irq_status;
  localparam int CNT_W = 8;
  localparam int NE    = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_in_ovr = 0, ev_in_udr = 0, ev_out_udr = 0, ev_bus_err = 0;
  logic ev_frame_start = 0, ev_frame_end = 0, ev_branch = 0;
  logic bias_toggle = 0, ctrl_enable = 0;
  logic [CNT_W-1:0] cfg_bias_limit = '0;
  logic reg_wr = 0, reg_addr = 0;
  logic [NE-1:0] reg_wdata = '0;
  logic [NE-1:0] reg_rdata;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  disp_irq_status #(.CNT_W(CNT_W)) i_disp_irq_status (
    .clk(clk), .rst(rst), .ev_in_ovr(ev_in_ovr), .ev_in_udr(ev_in_udr),
    .ev_out_udr(ev_out_udr), .ev_bus_err(ev_bus_err),
    .ev_frame_start(ev_frame_start), .ev_frame_end(ev_frame_end),
    .ev_branch(ev_branch), .bias_toggle(bias_toggle),
    .ctrl_enable(ctrl_enable), .cfg_bias_limit(cfg_bias_limit),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [NE-1:0] act, input logic [NE-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_strobes(input logic [NE-1:0] v);
    ev_in_ovr = v[0]; ev_in_udr = v[1]; ev_out_udr = v[2]; ev_bus_err = v[3];
    ev_frame_start = v[4]; ev_frame_end = v[5]; ev_branch = v[7];
  endtask

  task automatic pulse(input logic [NE-1:0] v);
    @(negedge clk); set_strobes(v);
    @(negedge clk); set_strobes('0);
  endtask

  task automatic wr(input logic a, input logic [NE-1:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [NE-1:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [NE-1:0] d;
    chk("R5 irq after reset", {8'h0, irq}, 9'h0);
    rd(1'b0, d); chk("R1 status after reset", d, 9'h000);
    rd(1'b1, d); chk("R4 mask after reset", d, 9'h1FF);
  endtask

  task automatic t_each_event;
    logic [NE-1:0] d;
    for (int i = 0; i < NE; i++) begin
      if (i == 6 || i == 8) continue;
      pulse(9'(1) << i);
      rd(1'b0, d); chk($sformatf("R1 bit %0d set", i), d, 9'(1) << i);
      chk("R6 masked irq low", {8'h0, irq}, 9'h0);
      wr(1'b0, 9'(1) << i);
      rd(1'b0, d); chk($sformatf("R2 bit %0d cleared", i), d, 9'h000);
    end
  endtask

  task automatic t_w1c;
    logic [NE-1:0] d;
    pulse(9'h009);
    wr(1'b0, 9'h000);
    rd(1'b0, d); chk("R2 write zero keeps", d, 9'h009);
    wr(1'b0, 9'h001);
    rd(1'b0, d); chk("R2 selective clear", d, 9'h008);
    wr(1'b0, 9'h1FF);
    rd(1'b0, d); chk("R2 clear all", d, 9'h000);
  endtask

  task automatic t_collision;
    logic [NE-1:0] d;
    pulse(9'h002);
    @(negedge clk); set_strobes(9'h002); reg_wr = 1; reg_addr = 0; reg_wdata = 9'h002;
    @(negedge clk); set_strobes('0); reg_wr = 0; reg_wdata = '0;
    rd(1'b0, d); chk("R3 event beats clear", d, 9'h002);
    wr(1'b0, 9'h002);
    rd(1'b0, d); chk("R3 later clear works", d, 9'h000);
  endtask

  task automatic t_irq_mask;
    logic [NE-1:0] d;
    wr(1'b1, 9'h0A5);
    rd(1'b1, d); chk("R4 mask readback", d, 9'h0A5);
    wr(1'b1, 9'h1FB);
    @(negedge clk); ev_out_udr = 1;
    @(negedge clk); ev_out_udr = 0;
    chk("R5 irq not yet", {8'h0, irq}, 9'h0);
    @(negedge clk); chk("R5 irq raised", {8'h0, irq}, 9'h1);
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = 9'h004;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
    chk("R5 irq one cycle after clear", {8'h0, irq}, 9'h1);
    @(negedge clk); chk("R5 irq dropped", {8'h0, irq}, 9'h0);
    wr(1'b1, 9'h1FF);
    pulse(9'h004);
    @(negedge clk); chk("R6 masked no irq", {8'h0, irq}, 9'h0);
    rd(1'b0, d); chk("R6 masked bit still set", d, 9'h004);
    wr(1'b1, 9'h1FB);
    @(negedge clk); chk("R6 unmask raises irq", {8'h0, irq}, 9'h1);
    wr(1'b1, 9'h1FF);
    @(negedge clk); chk("R6 remask drops irq", {8'h0, irq}, 9'h0);
    rd(1'b0, d); chk("R6 mask write kept status", d, 9'h004);
    wr(1'b0, 9'h004);
    rd(1'b0, d); chk("R6 masked bit clears", d, 9'h000);
  endtask

  task automatic t_bias;
    logic [NE-1:0] d;
    @(negedge clk); cfg_bias_limit = 8'd3;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); bias_toggle = 1; @(negedge clk); bias_toggle = 0;
    end
    rd(1'b0, d); chk("R7 no event before limit", d, 9'h000);
    @(negedge clk); bias_toggle = 1; @(negedge clk); bias_toggle = 0;
    rd(1'b0, d); chk("R7 event at limit", d, 9'h100);
    wr(1'b0, 9'h100);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); bias_toggle = 1; @(negedge clk); bias_toggle = 0;
    end
    rd(1'b0, d); chk("R7 count restarted", d, 9'h000);
    @(negedge clk); bias_toggle = 1; @(negedge clk); bias_toggle = 0;
    rd(1'b0, d); chk("R7 second period", d, 9'h100);
    wr(1'b0, 9'h100);
    @(negedge clk); cfg_bias_limit = 8'd0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); bias_toggle = 1; @(negedge clk); bias_toggle = 0;
    end
    rd(1'b0, d); chk("R7 zero limit disables", d, 9'h000);
  endtask

  task automatic t_lastframe;
    logic [NE-1:0] d;
    @(negedge clk); ctrl_enable = 1;
    pulse(9'h020);
    rd(1'b0, d); chk("R8 no last-done while enabled", d, 9'h020);
    wr(1'b0, 9'h1FF);
    @(negedge clk); ctrl_enable = 0;
    @(negedge clk);
    pulse(9'h020);
    rd(1'b0, d); chk("R8 last-done after disable", d, 9'h060);
    wr(1'b0, 9'h1FF);
    pulse(9'h020);
    rd(1'b0, d); chk("R8 fires only once", d, 9'h020);
    wr(1'b0, 9'h1FF);
    @(negedge clk); ctrl_enable = 1;
    @(negedge clk); ctrl_enable = 0;
    @(negedge clk);
    pulse(9'h020);
    rd(1'b0, d); chk("R8 rearmed by re-enable", d, 9'h060);
    wr(1'b0, 9'h1FF);
  endtask

  task automatic t_read_latency;
    logic [NE-1:0] d;
    wr(1'b1, 9'h13C);
    @(negedge clk); reg_addr = 1;
    @(negedge clk); reg_addr = 0; d = reg_rdata;
    chk("R9 mask shown one cycle later", d, 9'h13C);
    @(negedge clk); chk("R9 status after address switch", reg_rdata, 9'h000);
    wr(1'b1, 9'h1FF);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_each_event();
    t_w1c();
    t_collision();
    t_irq_mask();
    t_bias();
    t_lastframe();
    t_read_latency();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule